// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between the PWM modulator of a synchronous buck regulator and its gate drivers. It turns one PWM command into separate enables for the high-side and low-side switches. Neither switch may turn on until the other switch's gate-to-source voltage has been reported low. A parameterised minimum count of both-off cycles is also applied on every handover. The gate-discharge flags, and the comparator that reports a negative switch node, come from the analog side and are synchronised on entry.

For a start into an output that is already charged, a pre-bias mode lets the low side conduct only until the switch node goes negative. After that the low side stays blanked until the next PWM cycle tick, so the inductor current never reverses. Two override inputs sit above the normal path. A high-impedance request turns both switches off and raises an indicator. A force-low-side request clamps the output by holding the low side on. The block never times out a missing discharge flag. It waits with both switches off for as long as the flag is absent.

Top module: `gdc_gate_ctrl`

## Requirements
- R1: `hs_en` and `ls_en` are never high in the same cycle.
- R2: `ls_en` rises only when the synchronised `hs_vgs_low` was high in the cycle before. After `hs_vgs_low` rises, with every other condition met, `ls_en` rises SYNC_STAGES+1 cycles later.
- R3: `hs_en` rises only when the synchronised `ls_vgs_low` was high in the cycle before.
- R4: Between one enable falling and the other rising there are at least DEAD_MIN cycles with both enables low. When the flag is already present, the rise comes exactly DEAD_MIN+1 cycles after the command change.
- R5: With `prebias_en` high and no force, a high `phase_neg` drops `ls_en` SYNC_STAGES+1 cycles after it rises.
- R6: After the drop in R5, `ls_en` stays low until a `cycle_tick` pulse. It may rise again in the second cycle after the tick.
- R7: `hiz_req` drives both enables low and `hiz_o` high in the next cycle. `hiz_o` returns low one cycle after the request is removed.
- R8: While `force_ls` is high, `hs_en` stays low and `ls_en` is held on, regardless of `pwm_in`, `prebias_en` and `phase_neg`.
- R9: Priority is `hiz_req` over `force_ls`, and `force_ls` over `pwm_in`.
- R10: If the needed discharge flag never arrives, both enables stay low indefinitely.
- R11: After reset both enables and `hiz_o` are low.
- R12: When `pwm_in` falls, `hs_en` falls on the next clock edge, without waiting for any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, 1 requests high side |
| hs_vgs_low | input | 1 | High-side gate voltage below about 1 V (asynchronous) |
| ls_vgs_low | input | 1 | Low-side gate voltage below about 1 V (asynchronous) |
| phase_neg | input | 1 | Switch node below ground (asynchronous) |
| prebias_en | input | 1 | Pre-bias start mode, low side emulates a diode |
| force_ls | input | 1 | Hold the low side on, high side off |
| hiz_req | input | 1 | Turn both switches off |
| cycle_tick | input | 1 | One-cycle pulse at each PWM period start |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| hiz_o | output | 1 | Outputs are in high-impedance state |

## Verification
The bench builds the block with SYNC_STAGES=2 and DEAD_MIN=3. With these values the flag latency (three cycles) and the dead-time floor (four cycles to the rise) are different numbers. Each measured delay therefore shows which of the two limited a handover. Because the synchroniser has more than one stage, the bench can also check that the pre-bias drop and the flag-gated rises follow the synchronised flags and not the raw pins.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
   typedef enum logic [1:0] {
      GS_OFF = 2'd0,
      GS_HS  = 2'd1,
      GS_LS  = 2'd2
   } gdc_state_e;

   localparam int GDC_NFLAGS = 3;
   localparam int GDC_F_HS   = 0;
   localparam int GDC_F_LS   = 1;
   localparam int GDC_F_PN   = 2;
endpackage

// File: rtl/gdc_sync.sv
module gdc_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] sh [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) sh[i] <= '0;
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gdc_blank.sv
module gdc_blank (
   input  logic clk,
   input  logic rst_n,
   input  logic prebias_en,
   input  logic ls_on,
   input  logic pn_s,
   input  logic tick,
   output logic blank
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                blank <= 1'b0;
      else if (!prebias_en)      blank <= 1'b0;
      else if (tick)             blank <= 1'b0;
      else if (ls_on && pn_s)    blank <= 1'b1;
   end

   // R6
   blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blank && prebias_en && !tick) |=> blank);
endmodule

// File: rtl/gdc_seq.sv
module gdc_seq
   import gdc_pkg::*;
#(
   parameter int DEAD_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   input  logic force_ls,
   input  logic hiz_req,
   input  logic prebias_en,
   input  logic blank,
   input  logic hs_low_s,
   input  logic ls_low_s,
   input  logic pn_s,
   output logic hs_en,
   output logic ls_en,
   output logic hiz_o
);
   localparam int CW = (DEAD_MIN > 1) ? $clog2(DEAD_MIN) : 1;
   localparam logic [CW-1:0] CNT_TOP = CW'(DEAD_MIN - 1);

   gdc_state_e       state_q, state_d;
   logic [CW-1:0]    cnt_q, cnt_d;
   logic             want_hs, want_ls, ls_block, dead_ok;

   assign want_hs  = !hiz_req && !force_ls && pwm_in;
   assign ls_block = prebias_en && !force_ls && (blank || pn_s);
   assign want_ls  = !hiz_req && (force_ls || !pwm_in) && !ls_block;
   assign dead_ok  = (cnt_q >= CNT_TOP);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         GS_HS: if (!want_hs) begin
            state_d = GS_OFF;
            cnt_d   = '0;
         end
         GS_LS: if (!want_ls) begin
            state_d = GS_OFF;
            cnt_d   = '0;
         end
         default: begin
            if (dead_ok && want_hs && ls_low_s)      state_d = GS_HS;
            else if (dead_ok && want_ls && hs_low_s) state_d = GS_LS;
            else if (!dead_ok)                       cnt_d   = cnt_q + 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GS_OFF;
         cnt_q   <= '0;
         hiz_o   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         hiz_o   <= hiz_req;
      end
   end

   assign hs_en = (state_q == GS_HS);
   assign ls_en = (state_q == GS_LS);

   // R2
   ls_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> $past(hs_low_s));
   // R3
   hs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(ls_low_s));
   // R4
   hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(!ls_en));
   // R4
   ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> $past(!hs_en));
   // R5
   pn_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_en && prebias_en && pn_s && !force_ls) |=> !ls_en);
   // R6
   blank_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> !$past(blank && prebias_en && !force_ls));
   // R7
   hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_req |=> (!hs_en && !ls_en && hiz_o));
   // R8
   force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_ls |=> !hs_en);
   // R12
   pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en && !pwm_in) |=> !hs_en);
endmodule

// File: rtl/gdc_gate_ctrl.sv
module gdc_gate_ctrl
   import gdc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEAD_MIN    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   input  logic hs_vgs_low,
   input  logic ls_vgs_low,
   input  logic phase_neg,
   input  logic prebias_en,
   input  logic force_ls,
   input  logic hiz_req,
   input  logic cycle_tick,
   output logic hs_en,
   output logic ls_en,
   output logic hiz_o
);
   initial begin
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
      assert (DEAD_MIN >= 1 && DEAD_MIN <= 1024)
         else $error("DEAD_MIN out of range");
   end

   logic [GDC_NFLAGS-1:0] raw_f, syn_f;
   logic                  blank;

   assign raw_f[GDC_F_HS] = hs_vgs_low;
   assign raw_f[GDC_F_LS] = ls_vgs_low;
   assign raw_f[GDC_F_PN] = phase_neg;

   gdc_sync #(.STAGES(SYNC_STAGES), .WIDTH(GDC_NFLAGS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_f), .q(syn_f)
   );

   gdc_blank u_blank (
      .clk(clk), .rst_n(rst_n), .prebias_en(prebias_en), .ls_on(ls_en),
      .pn_s(syn_f[GDC_F_PN]), .tick(cycle_tick), .blank(blank)
   );

   gdc_seq #(.DEAD_MIN(DEAD_MIN)) u_seq (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .force_ls(force_ls),
      .hiz_req(hiz_req), .prebias_en(prebias_en), .blank(blank),
      .hs_low_s(syn_f[GDC_F_HS]), .ls_low_s(syn_f[GDC_F_LS]),
      .pn_s(syn_f[GDC_F_PN]), .hs_en(hs_en), .ls_en(ls_en), .hiz_o(hiz_o)
   );

   // R1
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));
endmodule

// File: tb/gdc_gate_ctrl_tb.sv
`timescale 1ns/1ps
module gdc_gate_ctrl_tb;
   localparam int SYNC = 2;
   localparam int DMIN = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_in = 0, hs_vgs_low = 0, ls_vgs_low = 0, phase_neg = 0;
   logic prebias_en = 0, force_ls = 0, hiz_req = 0, cycle_tick = 0;
   logic hs_en, ls_en, hiz_o;

   int n_chk = 0, n_fail = 0, n_overlap = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   gdc_gate_ctrl #(.SYNC_STAGES(SYNC), .DEAD_MIN(DMIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .hs_vgs_low(hs_vgs_low),
      .ls_vgs_low(ls_vgs_low), .phase_neg(phase_neg), .prebias_en(prebias_en),
      .force_ls(force_ls), .hiz_req(hiz_req), .cycle_tick(cycle_tick),
      .hs_en(hs_en), .ls_en(ls_en), .hiz_o(hiz_o)
   );

   always @(negedge clk) if (rst_n && hs_en && ls_en) n_overlap++;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // sel 0: hs_en, 1: ls_en; counts samples until the signal equals val
   task automatic count_until(input int sel, input logic val, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (((sel == 0) ? hs_en : ls_en) !== val && n < 50);
   endtask

   task automatic t_reset();
      check("R11 hs_en", hs_en, 0);
      check("R11 ls_en", ls_en, 0);
      check("R11 hiz_o", hiz_o, 0);
   endtask

   task automatic t_missing_flag_then_ls();
      int n;
      pwm_in = 0; hs_vgs_low = 0; ls_vgs_low = 1;
      step(12);
      check("R10 ls_en held off", ls_en, 0);
      check("R10 hs_en held off", hs_en, 0);
      hs_vgs_low = 1;
      count_until(1, 1'b1, n);
      check("R2 ls rise latency", n, SYNC + 1);
   endtask

   task automatic t_ls_to_hs();
      int n;
      step(); ls_vgs_low = 0; step(4);
      pwm_in = 1; ls_vgs_low = 1;
      step();
      check("R4 ls off first edge", ls_en, 0);
      count_until(0, 1'b1, n);
      check("R4 dead-time floor", n + 1, DMIN + 1);
   endtask

   task automatic t_hs_off_wait_flag();
      int n;
      step(); hs_vgs_low = 0; step(3);
      pwm_in = 0;
      step();
      check("R12 hs off next edge", hs_en, 0);
      step(8);
      check("R2 ls waits for hs flag", ls_en, 0);
      check("R3 hs stays off", hs_en, 0);
      hs_vgs_low = 1;
      count_until(1, 1'b1, n);
      check("R2 ls rise after flag", n, SYNC + 1);
      step(); ls_vgs_low = 0;
   endtask

   task automatic t_prebias();
      int n;
      prebias_en = 1;
      step(3);
      check("R5 ls on before phase_neg", ls_en, 1);
      phase_neg = 1;
      count_until(1, 1'b0, n);
      check("R5 phase_neg cut latency", n, SYNC + 1);
      phase_neg = 0;
      step(6);
      check("R6 ls stays blanked", ls_en, 0);
      cycle_tick = 1;
      step();
      cycle_tick = 0;
      check("R6 not on at tick edge", ls_en, 0);
      step();
      check("R6 ls back after tick", ls_en, 1);
   endtask

   task automatic t_force_and_hiz();
      int n;
      force_ls = 1; pwm_in = 1; phase_neg = 1;
      step(6);
      check("R8 ls held by force", ls_en, 1);
      check("R9 force over pwm", hs_en, 0);
      hiz_req = 1;
      step();
      check("R9 hiz over force ls", ls_en, 0);
      check("R9 hiz indicator", hiz_o, 1);
      hiz_req = 0;
      step();
      check("R7 hiz_o clears", hiz_o, 0);
      count_until(1, 1'b1, n);
      check("R8 ls back under force", ls_en, 1);
      force_ls = 0; phase_neg = 0; prebias_en = 0; ls_vgs_low = 1;
      step();
      check("R8 ls off after release", ls_en, 0);
      step(8);
      check("R3 hs on after release", hs_en, 1);
      hs_vgs_low = 0;
   endtask

   task automatic t_hiz();
      hiz_req = 1;
      step();
      check("R7 hs off", hs_en, 0);
      check("R7 hiz_o set", hiz_o, 1);
      step(5);
      check("R7 both held off", hs_en | ls_en, 0);
      hiz_req = 0;
      step();
      check("R7 hiz_o released", hiz_o, 0);
      step(8);
      check("R7 hs resumes", hs_en, 1);
   endtask

   initial begin
      step(3);
      rst_n = 1;
      step();
      t_reset();
      t_missing_flag_then_ls();
      t_ls_to_hs();
      t_hs_off_wait_flag();
      t_prebias();
      t_force_and_hiz();
      t_hiz();
      check("R1 no overlap cycles", n_overlap, 0);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule